// File: doc/BRIEF.md
# RC4 Keystream Cipher Core

This block encrypts a byte stream with the RC4 stream cipher. It processes one byte per clock. A host pulses the start input. The core then asks for the key with a one-clock request pulse and takes the key one byte per clock into a local buffer. Next it builds the 256-entry byte permutation, starting from the identity and stirring it with the key schedule. When setup is done the core raises a one-clock ready pulse.

From the ready cycle onward, the core reads one plaintext byte in every clock where the pause input is low. It XORs that byte with the next keystream byte and presents the ciphertext on the following clock. If the plaintext is tied to zero, the output is the raw keystream, so the core can also serve as a pseudo-random byte source. An abort input returns the core to idle from any phase.

Top module: `rc4c_top`

## Requirements
- R1: After reset (rst_n low) the core is idle: busy_o, key_req_o and pt_rdy_o are low and ct_o is 0x00.
- R2: A start_i pulse seen while idle makes key_req_o high in the next clock cycle, for exactly one cycle. busy_o stays high in every cycle until the core is idle again.
- R3: key_len_i is sampled together with start_i, and the values 1 to 256 are valid, with 256 encoded as 9'h100. The key bytes on key_i are captured one per clock, starting in the cycle after the key_req_o cycle, for key_len_i cycles.
- R4: pt_rdy_o is high for exactly one cycle. It rises key_len + 257 cycles after the key_req_o cycle: key_len load cycles followed by 256 key-schedule cycles.
- R5: ct_o follows standard RC4. The permutation starts as S[i]=i and the key schedule runs 256 steps. Each output byte is the plaintext byte XOR the next keystream byte, and it appears on ct_o one clock after pt_i was presented. The first plaintext byte is the one presented in the pt_rdy_o cycle.
- R6: With hold_i low, a new ciphertext byte is produced every clock with no gaps.
- R7: While hold_i is high in the generate phase, no keystream byte is consumed and ct_o stays unchanged. Once hold_i is low again, the stream continues with the next keystream byte.
- R8: stop_i high returns the core to idle in the next cycle from any phase. stop_i takes priority over start_i.
- R9: With pt_i held at 0x00, ct_o equals the raw RC4 keystream.
- R10: Key lengths at both limits, 1 byte and 256 bytes, give the correct RC4 stream, with the key index wrapping at the key length.
- R11: A start_i pulse while the core is busy is ignored, and the output stream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that begins key load and setup |
| stop_i | input | 1 | Abort to idle |
| hold_i | input | 1 | Pause keystream generation |
| key_len_i | input | 9 | Key length in bytes, 1 to 256 |
| key_i | input | 8 | Key byte, one per clock during key load |
| pt_i | input | 8 | Plaintext byte, one per clock during generation |
| key_req_o | output | 1 | One-cycle request for the key bytes |
| busy_o | output | 1 | High whenever the core is not idle |
| pt_rdy_o | output | 1 | One-cycle pulse marking the start of generation |
| ct_o | output | 8 | Ciphertext byte |

## Verification
The hardest situations to reach from the ports are an abort in the middle of the 256-step key schedule, and a pause or a stray start pulse in the middle of a running stream. In these cases a wrong index or a leftover permutation would show only in later bytes. The bench counts clocks from the key request so that it can place the stop pulse deep inside the schedule. It then restarts with a known vector, which shows that the permutation was rebuilt. Pause and stray start pulses are placed partway through a test vector, and every byte after them is compared.

// File: rtl/rc4c_pkg.sv
package rc4c_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_KREQ,
        PH_KLOAD,
        PH_KSCHED,
        PH_GEN
    } phase_e;
endpackage

// File: rtl/rc4c_keybuf.sv
module rc4c_keybuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rc4c_perm.sv
module rc4c_perm #(
    parameter int DW = 8,
    localparam int N = 2 ** DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          step_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] j_i,
    input  logic [DW-1:0] add_i,
    output logic [DW-1:0] nj_o,
    output logic [DW-1:0] ks_o
);
    logic [DW-1:0] s_q [N];
    logic [DW-1:0] s_d [N];
    logic [DW-1:0] si, sj, t;

    assign si   = s_q[a_i];
    assign nj_o = j_i + si + add_i;
    assign sj   = s_q[nj_o];
    assign t    = si + sj;
    // read the entry at t as it stands after the swap
    assign ks_o = (t == a_i) ? sj : ((t == nj_o) ? si : s_q[t]);

    always_comb begin
        for (int k = 0; k < N; k++) begin
            s_d[k] = init_i ? DW'(k) : s_q[k];
        end
        if (!init_i && step_i) begin
            s_d[a_i]  = sj;
            s_d[nj_o] = si;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) s_q[k] <= DW'(k);
        end else begin
            for (int k = 0; k < N; k++) s_q[k] <= s_d[k];
        end
    end

    p_init_ident_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (s_q[N-1] == DW'(N-1) && s_q[1] == DW'(1)));
endmodule

// File: rtl/rc4c_top.sv
module rc4c_top #(
    parameter int DW = 8,
    localparam int N  = 2 ** DW,
    localparam int KW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          hold_i,
    input  logic [KW-1:0] key_len_i,
    input  logic [DW-1:0] key_i,
    input  logic [DW-1:0] pt_i,
    output logic          key_req_o,
    output logic          busy_o,
    output logic          pt_rdy_o,
    output logic [DW-1:0] ct_o
);
    import rc4c_pkg::*;

    typedef struct packed {
        phase_e        ph;
        logic [DW-1:0] i;
        logic [DW-1:0] j;
        logic [KW-1:0] kc;
        logic [KW-1:0] len;
        logic          first;
        logic [DW-1:0] ct;
    } regs_t;

    regs_t q, d;
    logic          kb_we, p_init, p_step;
    logic [DW-1:0] p_a, p_add, p_nj, p_ks, kb_rdata;

    rc4c_keybuf #(.DW(DW), .DEPTH(N)) u_kbuf (
        .clk     (clk),
        .we_i    (kb_we),
        .addr_i  (q.kc[DW-1:0]),
        .wdata_i (key_i),
        .rdata_o (kb_rdata)
    );

    rc4c_perm #(.DW(DW)) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (p_init),
        .step_i (p_step),
        .a_i    (p_a),
        .j_i    (q.j),
        .add_i  (p_add),
        .nj_o   (p_nj),
        .ks_o   (p_ks)
    );

    always_comb begin
        d       = q;
        d.first = 1'b0;
        kb_we   = 1'b0;
        p_init  = 1'b0;
        p_step  = 1'b0;
        p_a     = q.i;
        p_add   = '0;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph   = PH_KREQ;
                    p_init = 1'b1;
                    d.len  = key_len_i;
                    d.kc   = '0;
                    d.i    = '0;
                    d.j    = '0;
                end
            end
            PH_KREQ: d.ph = PH_KLOAD;
            PH_KLOAD: begin
                kb_we = 1'b1;
                d.kc  = q.kc + 1'b1;
                if (q.kc == q.len - 1'b1) begin
                    d.ph = PH_KSCHED;
                    d.kc = '0;
                end
            end
            PH_KSCHED: begin
                p_step = 1'b1;
                p_a    = q.i;
                p_add  = kb_rdata;
                d.j    = p_nj;
                d.i    = q.i + 1'b1;
                d.kc   = (q.kc == q.len - 1'b1) ? '0 : q.kc + 1'b1;
                if (q.i == DW'(N-1)) begin
                    d.ph    = PH_GEN;
                    d.first = 1'b1;
                    d.i     = '0;
                    d.j     = '0;
                end
            end
            PH_GEN: begin
                if (!hold_i) begin
                    p_step = 1'b1;
                    p_a    = q.i + 1'b1;
                    d.i    = q.i + 1'b1;
                    d.j    = p_nj;
                    d.ct   = p_ks ^ pt_i;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
        if (stop_i) begin
            d.ph    = PH_IDLE;
            d.first = 1'b0;
            kb_we   = 1'b0;
            p_init  = 1'b0;
            p_step  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign key_req_o = (q.ph == PH_KREQ);
    assign busy_o    = (q.ph != PH_IDLE);
    assign pt_rdy_o  = q.first;
    assign ct_o      = q.ct;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!key_req_o && !pt_rdy_o));
    p_start_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !stop_i) |=> key_req_o);
    p_req_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_req_o |=> !key_req_o);
    p_rdy_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_rdy_o |=> !pt_rdy_o);
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_GEN && hold_i && !stop_i) |=> $stable(ct_o));
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !busy_o);
endmodule

// File: tb/sim_rc4c_top.sv
module sim_rc4c_top;
    localparam int PERIOD = 10;
    localparam int NV = 3;
    localparam logic [63:0]  TKEY [NV] = '{"Key", "Wiki", "Secret"};
    localparam int           TKL  [NV] = '{3, 4, 6};
    localparam logic [127:0] TPT  [NV] = '{"Plaintext", "pedia", "Attack at dawn"};
    localparam int           TPL  [NV] = '{9, 5, 14};
    localparam logic [127:0] TCT  [NV] = '{128'hBBF316E8D940AF0AD3, 128'h1021BF0420,
                                           128'h45A01F645FC35B383552544B9BF5};

    logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0, hold_i = 1'b0;
    logic [8:0] key_len_i = '0;
    logic [7:0] key_i = '0, pt_i = '0;
    logic key_req_o, busy_o, pt_rdy_o;
    logic [7:0] ct_o;

    int errors = 0, checks = 0;
    logic [7:0] bkey [256];
    logic [7:0] bpt  [64];
    logic [7:0] bks  [64];

    always #(PERIOD/2) clk = ~clk;

    rc4c_top u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
                 .hold_i(hold_i), .key_len_i(key_len_i), .key_i(key_i), .pt_i(pt_i),
                 .key_req_o(key_req_o), .busy_o(busy_o), .pt_rdy_o(pt_rdy_o), .ct_o(ct_o));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input int klen, input int cnt);
        logic [7:0] s [256];
        logic [7:0] j, i, tmp;
        for (int k = 0; k < 256; k++) s[k] = 8'(k);
        j = 0;
        for (int k = 0; k < 256; k++) begin
            j = j + s[k] + bkey[k % klen];
            tmp = s[k]; s[k] = s[j]; s[j] = tmp;
        end
        i = 0; j = 0;
        for (int n = 0; n < cnt; n++) begin
            i = i + 1; j = j + s[i];
            tmp = s[i]; s[i] = s[j]; s[j] = tmp;
            bks[n] = s[8'(s[i] + s[j])];
        end
    endtask

    // start, feed key, wait for ready; leaves the bench at the ready negedge
    task automatic setup(input int klen);
        int cnt;
        @(negedge clk);
        start_i = 1'b1; key_len_i = (klen == 256) ? 9'h100 : 9'(klen);
        @(negedge clk);
        start_i = 1'b0; key_len_i = 9'h0AA;
        chk("R2 key request after start", {15'd0, key_req_o}, 16'd1);
        chk("R2 busy after start", {15'd0, busy_o}, 16'd1);
        for (int k = 0; k < klen; k++) begin
            @(negedge clk);
            key_i = bkey[k];
            if (k == 0) chk("R2 key request one cycle", {15'd0, key_req_o}, 16'd0);
        end
        @(negedge clk);
        key_i = 8'h00;
        cnt = klen + 1;
        while (!pt_rdy_o && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4 ready latency", 16'(cnt), 16'(klen + 257));
    endtask

    // stream cnt bytes from the ready negedge; optional hold or stray start at byte hat/sat
    task automatic stream(input int cnt, input string tag, input int hat, input int sat);
        logic [7:0] held;
        pt_i = bpt[0];
        for (int n = 1; n <= cnt; n++) begin
            @(negedge clk);
            start_i = 1'b0;
            chk(tag, {8'd0, ct_o}, {8'd0, bpt[n-1] ^ bks[n-1]});
            if (n == 1) chk("R4 ready one cycle", {15'd0, pt_rdy_o}, 16'd0);
            if (n == hat && n < cnt) begin
                held = ct_o;
                hold_i = 1'b1;
                pt_i = 8'hFF;
                for (int h = 0; h < 3; h++) begin
                    @(negedge clk);
                    chk("R7 output frozen under hold", {8'd0, ct_o}, {8'd0, held});
                end
                hold_i = 1'b0;
            end
            if (n == sat) start_i = 1'b1;
            if (n < cnt) pt_i = bpt[n];
        end
        pt_i = 8'h00;
    endtask

    task automatic load_vec(input int v);
        for (int k = 0; k < TKL[v]; k++) bkey[k] = TKEY[v][8*(TKL[v]-1-k) +: 8];
        for (int n = 0; n < TPL[v]; n++) begin
            bpt[n] = TPT[v][8*(TPL[v]-1-n) +: 8];
            bks[n] = TCT[v][8*(TPL[v]-1-n) +: 8] ^ bpt[n];
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", {15'd0, busy_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 key request idle", {15'd0, key_req_o}, 16'd0);
        chk("R1 ready idle", {15'd0, pt_rdy_o}, 16'd0);
        chk("R1 ciphertext cleared", {8'd0, ct_o}, 16'd0);
        chk("R1 busy idle", {15'd0, busy_o}, 16'd0);

        // table of known vectors; R3 key capture, R5 cipher, R6 rate
        for (int v = 0; v < NV; v++) begin
            load_vec(v);
            setup(TKL[v]);
            stream(TPL[v], (v == 0) ? "R5 R3 vector" : "R6 R5 vector", 0, 0);
            @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        end

        // R9: zero plaintext gives raw keystream
        load_vec(0);
        for (int n = 0; n < TPL[0]; n++) bpt[n] = 8'h00;
        setup(3);
        stream(9, "R9 raw keystream", 0, 0);
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;

        // R7 hold and R11 stray start mid-stream
        load_vec(2);
        setup(6);
        stream(14, "R7 R11 stream continuity", 5, 9);
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        chk("R8 idle after stop in generate", {15'd0, busy_o}, 16'd0);

        // R8: abort deep in the key schedule, then stop beats start
        for (int k = 0; k < 4; k++) bkey[k] = 8'hC3 + 8'(k);
        @(negedge clk); start_i = 1'b1; key_len_i = 9'd4;
        @(negedge clk); start_i = 1'b0;
        repeat (120) @(negedge clk);
        chk("R8 busy during schedule", {15'd0, busy_o}, 16'd1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R8 idle after stop", {15'd0, busy_o}, 16'd0);
        start_i = 1'b1; stop_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
        chk("R8 stop wins over start", {15'd0, busy_o}, 16'd0);
        chk("R8 no key request", {15'd0, key_req_o}, 16'd0);
        load_vec(1);
        setup(4);
        stream(5, "R8 restart after abort", 0, 0);
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;

        // R10: key length limits
        bkey[0] = 8'h5A;
        model(1, 16);
        for (int n = 0; n < 16; n++) bpt[n] = 8'(n * 17 + 1);
        setup(1);
        stream(16, "R10 one-byte key", 0, 0);
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
        for (int k = 0; k < 256; k++) bkey[k] = 8'(k * 7 + 3);
        model(256, 16);
        setup(256);
        stream(16, "R10 256-byte key", 0, 0);
        @(negedge clk); stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule